// File: doc/BRIEF.md
# Low-Frequency Match Timer

This block is a 32-bit timer that counts edges of a slow oscillator, nominally 32.768 kHz, while software reaches it through a simple register port running on a much faster system clock. It provides a free-running counter, a rate divider (trim), a way to load the count directly and a compare value. When the counter steps onto the compare value, an interrupt is raised. Typical use is as a one-shot event source: software reads the count, adds a delta, writes the sum as the compare value and waits for the interrupt.

The slow domain holds every value that affects counting. Each register write therefore has to cross into that domain. Each of the three crossing targets has its own busy flag in a status register, and software polls that flag before writing the same target again. The current count comes back through a handshake snapshot, so the system side never sees a value that is half old and half new. A sticky status bit shows whether the slow clock has ever toggled since reset.

Register map (word address on `addr`): 0 control, 1 status (read only), 2 trim, 3 count, 4 compare, 5 pending.

Top module: `lf_match_timer`

## Requirements
- R1: After reset, control (address 0), pending (address 5) and count (address 3) read 0, status (address 1) reads 0 and `irq` is low.
- R2: Status bit 0 (oscillator seen) reads 0 until the slow clock has toggled after reset. It then becomes 1 within a few system cycles and stays 1, even if the slow clock stops, until the next reset.
- R3: Status bit 4 (ready) reads 1 exactly when control bit 0 (run) and status bit 0 are both 1.
- R4: With trim 0 and run set, the count advances by one on every slow clock edge. With run clear, the count holds its value.
- R5: With a nonzero trim value N (address 2), the count advances once every N+1 slow clock edges.
- R6: Status bits 1, 2 and 3 are the busy flags for trim, count and compare. Each flag is set in the system cycle after an accepted write to its target. It clears only after the value has been taken into the slow domain, and it stays set while the slow clock is stopped.
- R7: A write to a target whose busy flag is set is dropped. The value read back from that target and the value used in the slow domain stay unchanged.
- R8: Writing address 3 loads the written value into the counter. Reading address 3 returns a coherent snapshot of the count.
- R9: The count wraps from 0xFFFFFFFF to 0 and continues counting.
- R10: When the counter advances onto the compare value (address 4), pending bit 0 (address 5) is set. `irq` equals pending bit 0 AND control bit 1 (interrupt enable).
- R11: Writing 1 to pending bit 0 clears it, and writing 0 leaves it unchanged. If a new compare hit arrives in the same cycle as the clear, the hit wins.
- R12: At trim 0, a compare value equal to a freshly read count plus 9 still produces a hit, despite the crossing latency of both the read and the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock for the register port |
| clk_lf | input | 1 | Slow oscillator clock that drives counting |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write strobe, one system cycle per write |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational from registers) |
| irq | output | 1 | Level interrupt: compare pending and enabled |

## Verification
The hardest condition to reach is a busy flag that stays set long enough for a second write to land on it. The two domains normally finish a crossing within a few slow edges, so that window is short. The bench gates the slow clock off, writes the compare target twice, and then checks the busy flag, the read-back value and the sticky oscillator bit before it restarts the clock. The minimum-delta case is reached by leaving the counter running at full rate, reading the snapshot, and writing that value plus 9 straight away, so the read and write crossing latencies add up in the same way they would for real software.

// File: rtl/lft_pkg.sv
package lft_pkg;
  localparam int CNT_W       = 32;
  localparam int ADDR_W      = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_TRIM  = 3'd2,
    A_COUNT = 3'd3,
    A_MATCH = 3'd4,
    A_PEND  = 3'd5
  } reg_addr_e;

  // write-crossing channels
  localparam int CH_TRIM  = 0;
  localparam int CH_LOAD  = 1;
  localparam int CH_MATCH = 2;
  localparam int NUM_WCH  = 3;

  // control bits
  localparam int C_RUN = 0;
  localparam int C_IEN = 1;
  localparam int CTRL_W = 2;

  // status bits
  localparam int ST_OSC   = 0;
  localparam int ST_BUSY0 = 1;
  localparam int ST_READY = ST_BUSY0 + NUM_WCH;
endpackage

// File: rtl/lft_sync.sv
module lft_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lft_rst_sync.sv
module lft_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  lft_sync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (arst_n),
    .d     (1'b1),
    .q     (rst_n_o)
  );
endmodule

// File: rtl/lft_wr_xfer.sv
// One write target: system-side shadow plus toggle handshake into the slow domain.
module lft_wr_xfer #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_sys,
  input  logic         rst_sys_n,
  input  logic         clk_lf,
  input  logic         rst_lf_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic [W-1:0] shadow_o,
  output logic         lf_apply_o
);
  logic         req_q, req_d;
  logic [W-1:0] shadow_q, shadow_d;
  logic         ack_sys;
  logic         req_lf;
  logic         ack_lf_q, ack_lf_d;

  // system side
  lft_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk (clk_sys), .rst_n (rst_sys_n), .d (ack_lf_q), .q (ack_sys)
  );

  assign busy_o = req_q ^ ack_sys;

  always_comb begin
    req_d    = req_q;
    shadow_d = shadow_q;
    if (wr_i && !busy_o) begin
      req_d    = ~req_q;
      shadow_d = wdata_i;
    end
  end

  always_ff @(posedge clk_sys or negedge rst_sys_n) begin
    if (!rst_sys_n) begin
      req_q    <= 1'b0;
      shadow_q <= '0;
    end else begin
      req_q    <= req_d;
      shadow_q <= shadow_d;
    end
  end

  assign shadow_o = shadow_q;

  // slow side: shadow is held steady while the request is outstanding
  lft_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk (clk_lf), .rst_n (rst_lf_n), .d (req_q), .q (req_lf)
  );

  assign lf_apply_o = req_lf ^ ack_lf_q;
  assign ack_lf_d   = req_lf;

  always_ff @(posedge clk_lf or negedge rst_lf_n) begin
    if (!rst_lf_n) ack_lf_q <= 1'b0;
    else           ack_lf_q <= ack_lf_d;
  end

  // R6: an accepted write raises busy in the next system cycle
  a_r6_busy_after_write: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    (wr_i && !busy_o) |=> busy_o);

  // R7: the shadow is frozen while its crossing is outstanding
  a_r7_shadow_frozen: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    busy_o |=> $stable(shadow_o));
endmodule

// File: rtl/lft_rd_snap.sv
// Continuous handshake snapshot of a slow-domain value into the system domain.
module lft_rd_snap #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_sys,
  input  logic         rst_sys_n,
  input  logic         clk_lf,
  input  logic         rst_lf_n,
  input  logic [W-1:0] lf_val_i,
  output logic [W-1:0] sys_val_o
);
  logic         rq_q, rq_d;
  logic [W-1:0] val_q, val_d;
  logic         ak_sys, done;
  logic         rq_lf;
  logic         ak_lf_q, ak_lf_d;
  logic [W-1:0] snap_lf_q, snap_lf_d;

  lft_sync #(.W(1), .STAGES(STAGES)) u_ak_sync (
    .clk (clk_sys), .rst_n (rst_sys_n), .d (ak_lf_q), .q (ak_sys)
  );

  assign done = (rq_q == ak_sys);

  always_comb begin
    rq_d  = rq_q;
    val_d = val_q;
    if (done) begin
      val_d = snap_lf_q;
      rq_d  = ~rq_q;
    end
  end

  always_ff @(posedge clk_sys or negedge rst_sys_n) begin
    if (!rst_sys_n) begin
      rq_q  <= 1'b0;
      val_q <= '0;
    end else begin
      rq_q  <= rq_d;
      val_q <= val_d;
    end
  end

  assign sys_val_o = val_q;

  lft_sync #(.W(1), .STAGES(STAGES)) u_rq_sync (
    .clk (clk_lf), .rst_n (rst_lf_n), .d (rq_q), .q (rq_lf)
  );

  always_comb begin
    ak_lf_d   = ak_lf_q;
    snap_lf_d = snap_lf_q;
    if (rq_lf != ak_lf_q) begin
      ak_lf_d   = rq_lf;
      snap_lf_d = lf_val_i;
    end
  end

  always_ff @(posedge clk_lf or negedge rst_lf_n) begin
    if (!rst_lf_n) begin
      ak_lf_q   <= 1'b0;
      snap_lf_q <= '0;
    end else begin
      ak_lf_q   <= ak_lf_d;
      snap_lf_q <= snap_lf_d;
    end
  end

  // R8: the visible count changes only when a snapshot round trip completes
  a_r8_snapshot_steady: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    !done |=> $stable(sys_val_o));
endmodule

// File: rtl/lft_lf_core.sv
// Slow-domain prescaler, counter and compare.
module lft_lf_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             trim_ld_i,
  input  logic [CNT_W-1:0] trim_data_i,
  input  logic             load_ld_i,
  input  logic [CNT_W-1:0] load_data_i,
  input  logic             match_ld_i,
  input  logic [CNT_W-1:0] match_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_tgl_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] trim_q, trim_d;
  logic [CNT_W-1:0] match_q, match_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit_q, hit_d;
  logic             tick, step, hit;

  assign tick = (div_q == trim_q);
  assign step = run_i && tick && !load_ld_i;
  assign hit  = step && ((cnt_q + ONE) == match_q);

  always_comb begin
    div_d   = div_q;
    trim_d  = trim_q;
    match_d = match_q;
    cnt_d   = cnt_q;
    hit_d   = hit_q;

    if (trim_ld_i) begin
      trim_d = trim_data_i;
      div_d  = '0;
    end else if (run_i) begin
      div_d = tick ? '0 : div_q + ONE;
    end

    if (match_ld_i) match_d = match_data_i;

    if (load_ld_i)  cnt_d = load_data_i;
    else if (step)  cnt_d = cnt_q + ONE;

    if (hit) hit_d = ~hit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      trim_q  <= '0;
      match_q <= '0;
      cnt_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      div_q   <= div_d;
      trim_q  <= trim_d;
      match_q <= match_d;
      cnt_q   <= cnt_d;
      hit_q   <= hit_d;
    end
  end

  assign count_o   = cnt_q;
  assign hit_tgl_o = hit_q;

  // R4/R9: without a load the count either holds or steps by one (modulo 2^CNT_W)
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ld_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE));

  // R4: a stopped counter holds its value
  a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lf_match_timer.sv
module lf_match_timer
  import lft_pkg::*;
(
  input  logic              clk_sys,
  input  logic              clk_lf,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  logic rst_sys_n, rst_lf_n;

  lft_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sys (
    .clk (clk_sys), .arst_n (rst_n), .rst_n_o (rst_sys_n)
  );
  lft_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_lf (
    .clk (clk_lf), .arst_n (rst_n), .rst_n_o (rst_lf_n)
  );

  // ---------------- write channels ----------------
  logic [NUM_WCH-1:0]            wr_ch;
  logic [NUM_WCH-1:0]            busy;
  logic [NUM_WCH-1:0]            apply_lf;
  logic [NUM_WCH-1:0][CNT_W-1:0] shadow;

  assign wr_ch[CH_TRIM]  = wr_en && (addr == A_TRIM);
  assign wr_ch[CH_LOAD]  = wr_en && (addr == A_COUNT);
  assign wr_ch[CH_MATCH] = wr_en && (addr == A_MATCH);

  for (genvar g = 0; g < NUM_WCH; g++) begin : g_wch
    lft_wr_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_xfer (
      .clk_sys    (clk_sys),
      .rst_sys_n  (rst_sys_n),
      .clk_lf     (clk_lf),
      .rst_lf_n   (rst_lf_n),
      .wr_i       (wr_ch[g]),
      .wdata_i    (wdata),
      .busy_o     (busy[g]),
      .shadow_o   (shadow[g]),
      .lf_apply_o (apply_lf[g])
    );
  end

  // ---------------- control register ----------------
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && (addr == A_CTRL)) ctrl_d = wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk_sys or negedge rst_sys_n) begin
    if (!rst_sys_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  logic run_lf;
  lft_sync #(.W(1), .STAGES(SYNC_STAGES)) u_run_sync (
    .clk (clk_lf), .rst_n (rst_lf_n), .d (ctrl_q[C_RUN]), .q (run_lf)
  );

  // ---------------- slow-domain core ----------------
  logic [CNT_W-1:0] count_lf;
  logic             hit_tgl_lf;

  lft_lf_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk_lf),
    .rst_n        (rst_lf_n),
    .run_i        (run_lf),
    .trim_ld_i    (apply_lf[CH_TRIM]),
    .trim_data_i  (shadow[CH_TRIM]),
    .load_ld_i    (apply_lf[CH_LOAD]),
    .load_data_i  (shadow[CH_LOAD]),
    .match_ld_i   (apply_lf[CH_MATCH]),
    .match_data_i (shadow[CH_MATCH]),
    .count_o      (count_lf),
    .hit_tgl_o    (hit_tgl_lf)
  );

  logic [CNT_W-1:0] count_sys;
  lft_rd_snap #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_snap (
    .clk_sys   (clk_sys),
    .rst_sys_n (rst_sys_n),
    .clk_lf    (clk_lf),
    .rst_lf_n  (rst_lf_n),
    .lf_val_i  (count_lf),
    .sys_val_o (count_sys)
  );

  // ---------------- oscillator presence ----------------
  // Toggles on every slow edge; reset by the raw reset so the first edge counts.
  logic alive_lf_q;
  always_ff @(posedge clk_lf or negedge rst_n) begin
    if (!rst_n) alive_lf_q <= 1'b0;
    else        alive_lf_q <= ~alive_lf_q;
  end

  logic alive_sys, alive_prev_q, alive_prev_d;
  logic osc_seen_q, osc_seen_d;

  lft_sync #(.W(1), .STAGES(SYNC_STAGES)) u_alive_sync (
    .clk (clk_sys), .rst_n (rst_sys_n), .d (alive_lf_q), .q (alive_sys)
  );

  assign alive_prev_d = alive_sys;
  assign osc_seen_d   = osc_seen_q | (alive_sys ^ alive_prev_q);

  always_ff @(posedge clk_sys or negedge rst_sys_n) begin
    if (!rst_sys_n) begin
      alive_prev_q <= 1'b0;
      osc_seen_q   <= 1'b0;
    end else begin
      alive_prev_q <= alive_prev_d;
      osc_seen_q   <= osc_seen_d;
    end
  end

  // ---------------- compare pending ----------------
  logic hit_sys, hit_prev_q, hit_prev_d, hit_evt;
  logic pend_q, pend_d, pend_clr;

  lft_sync #(.W(1), .STAGES(SYNC_STAGES)) u_hit_sync (
    .clk (clk_sys), .rst_n (rst_sys_n), .d (hit_tgl_lf), .q (hit_sys)
  );

  assign hit_evt    = hit_sys ^ hit_prev_q;
  assign hit_prev_d = hit_sys;
  assign pend_clr   = wr_en && (addr == A_PEND) && wdata[0];

  always_comb begin
    pend_d = pend_q;
    if (pend_clr) pend_d = 1'b0;
    if (hit_evt)  pend_d = 1'b1;
  end

  always_ff @(posedge clk_sys or negedge rst_sys_n) begin
    if (!rst_sys_n) begin
      hit_prev_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      hit_prev_q <= hit_prev_d;
      pend_q     <= pend_d;
    end
  end

  assign irq = pend_q & ctrl_q[C_IEN];

  // ---------------- read mux ----------------
  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
      A_STAT: begin
        rdata[ST_OSC] = osc_seen_q;
        for (int i = 0; i < NUM_WCH; i++) rdata[ST_BUSY0+i] = busy[i];
        rdata[ST_READY] = ctrl_q[C_RUN] & osc_seen_q;
      end
      A_TRIM:  rdata = shadow[CH_TRIM];
      A_COUNT: rdata = count_sys;
      A_MATCH: rdata = shadow[CH_MATCH];
      A_PEND:  rdata[0] = pend_q;
      default: rdata = '0;
    endcase
  end

  // R2: oscillator-seen never falls back without a reset
  a_r2_osc_sticky: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    osc_seen_q |=> osc_seen_q);

  // R10/R11: a compare hit always leaves the pending bit set, even against a clear
  a_r10_hit_sets_pending: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    hit_evt |=> pend_q);

  // R11: a clear with no concurrent hit empties the pending bit
  a_r11_w1c_clears: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    (pend_clr && !hit_evt) |=> !pend_q);
endmodule

// File: tb/sim_lf_match_timer.sv
`timescale 1ns/1ps
module sim_lf_match_timer;
  localparam int SLOW_CYC = 40;   // system cycles per slow clock period
  localparam logic [31:0] BUSY_MASK = 32'h0000_000E;

  // trim, slow periods run, expected count low, expected count high
  localparam logic [31:0] RATE_TAB [4][4] = '{
    '{32'd0, 32'd40, 32'd39, 32'd41},
    '{32'd1, 32'd40, 32'd19, 32'd21},
    '{32'd3, 32'd40, 32'd9,  32'd11},
    '{32'd9, 32'd40, 32'd3,  32'd5 }
  };

  logic        clk_sys = 1'b0;
  logic        clk_lf  = 1'b0;
  logic        lf_on   = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk_sys = ~clk_sys;
  always #100 if (lf_on) clk_lf = ~clk_lf;

  lf_match_timer u0 (
    .clk_sys (clk_sys), .clk_lf (clk_lf), .rst_n (rst_n),
    .wr_en (wr_en), .addr (addr), .wdata (wdata), .rdata (rdata), .irq (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input logic [31:0] act,
                         input logic [31:0] lo, input logic [31:0] hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_sys);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk_sys);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_slow(input int n);
    repeat (n * SLOW_CYC) @(negedge clk_sys);
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] st;
    bit ok;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_sys);
      rd(3'd1, st);
      if ((st & BUSY_MASK) == 0) begin
        ok = 1'b1;
        break;
      end
    end
    if (!ok) chk(tag, st & BUSY_MASK, 32'h0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk_sys);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, c1, c2;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk_sys);
    rst_n = 1'b1;
    repeat (10) @(negedge clk_sys);

    // R1: reset state
    rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(3'd1, v); chk("R1 status", v, 32'h0);
    rd(3'd5, v); chk("R1 pending", v, 32'h0);
    rd(3'd3, v); chk("R1 count", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2: no slow clock yet
    repeat (200) @(negedge clk_sys);
    rd(3'd1, v); chk("R2 osc before clock", v & 32'h1, 32'h0);
    // R3: run alone is not ready
    wr(3'd0, 32'h1);
    rd(3'd1, v); chk("R3 ready without osc", v & 32'h10, 32'h0);

    lf_on = 1'b1;
    wait_slow(5);
    rd(3'd1, v); chk("R2 osc after clock", v & 32'h1, 32'h1);
    chk("R3 ready with run and osc", v & 32'h10, 32'h10);
    wr(3'd0, 32'h0);
    rd(3'd1, v); chk("R3 ready run cleared", v & 32'h10, 32'h0);

    // R4/R5: rate table
    for (int k = 0; k < 4; k++) begin
      wr(3'd0, 32'h0);
      wait_slow(6);
      wr(3'd3, 32'h0);
      wait_idle("R6 load idle");
      wr(3'd2, RATE_TAB[k][0]);
      rd(3'd1, v); chk("R6 trim busy set", v & 32'h2, 32'h2);
      wait_idle("R6 trim idle");
      rd(3'd2, v); chk("R5 trim readback", v, RATE_TAB[k][0]);
      wr(3'd0, 32'h1);
      wait_slow(int'(RATE_TAB[k][1]));
      wr(3'd0, 32'h0);
      wait_slow(6);
      rd(3'd3, v);
      if (RATE_TAB[k][0] == 0) chk_rng("R4 full rate count", v, RATE_TAB[k][2], RATE_TAB[k][3]);
      else                     chk_rng("R5 divided count", v, RATE_TAB[k][2], RATE_TAB[k][3]);
    end

    // R8: load, R4: hold when stopped
    wr(3'd3, 32'h1234_5678);
    rd(3'd1, v); chk("R6 count busy set", v & 32'h4, 32'h4);
    wait_idle("R8 load idle");
    wait_slow(6);
    rd(3'd3, c1); chk("R8 loaded count", c1, 32'h1234_5678);
    wait_slow(10);
    rd(3'd3, c2); chk("R4 hold while stopped", c2, c1);

    // R9: wrap
    wr(3'd2, 32'h0);
    wait_idle("R9 trim idle");
    wr(3'd3, 32'hFFFF_FFFE);
    wait_idle("R9 load idle");
    wr(3'd0, 32'h1);
    wait_slow(4);
    wr(3'd0, 32'h0);
    wait_slow(6);
    rd(3'd3, v); chk_rng("R9 wrapped count", v, 32'd1, 32'd3);

    // R10: compare hit and irq gating
    wr(3'd5, 32'h1);
    wr(3'd3, 32'd100);
    wait_idle("R10 load idle");
    wr(3'd4, 32'd110);
    rd(3'd1, v); chk("R6 match busy set", v & 32'h8, 32'h8);
    wait_idle("R10 match idle");
    wr(3'd0, 32'h1);
    wait_slow(5);
    rd(3'd5, v); chk("R10 no hit before match", v, 32'h0);
    wait_slow(15);
    rd(3'd5, v); chk("R10 hit sets pending", v, 32'h1);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h3);
    chk("R10 irq enabled", {31'b0, irq}, 32'h1);

    // R11: write-one-to-clear
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R11 write zero keeps pending", v, 32'h1);
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R11 write one clears", v, 32'h0);
    chk("R11 irq drops", {31'b0, irq}, 32'h0);

    // R12: minimum delta of 9 ticks at full rate
    rd(3'd3, c1);
    wr(3'd4, c1 + 32'd9);
    wait_slow(20);
    rd(3'd5, v); chk("R12 delta 9 hits", v, 32'h1);
    chk("R12 irq", {31'b0, irq}, 32'h1);
    wr(3'd5, 32'h1);
    wait_idle("R12 idle");

    // R6/R7: stalled slow clock
    lf_on = 1'b0;
    wr(3'd4, 32'h111);
    rd(3'd1, v); chk("R6 busy after write", v & 32'h8, 32'h8);
    wr(3'd4, 32'h222);
    repeat (200) @(negedge clk_sys);
    rd(3'd1, v); chk("R6 busy held without clock", v & 32'h8, 32'h8);
    chk("R2 osc sticky without clock", v & 32'h1, 32'h1);
    rd(3'd4, v); chk("R7 second write dropped", v, 32'h111);
    lf_on = 1'b1;
    wait_idle("R6 idle after restart");
    rd(3'd4, v); chk("R7 first value kept", v, 32'h111);
    wr(3'd4, 32'h222);
    wait_idle("R7 idle");
    rd(3'd4, v); chk("R7 write accepted when idle", v, 32'h222);

    summary();
    $finish;
  end
endmodule